// File: doc/BRIEF.md
# Variable character field isolator

This unit pulls a bit field of variable length out of a 48-bit data word and returns it right-justified, with all bits above the field cleared. The word is treated as eight 6-bit characters. Bit position 0 is the most significant bit, held in vector bit 47. The field starts at a character index and a bit offset within that character. Its length comes from a 6-bit operation code. The upper three bits of that code give a count of whole characters. The lower three bits give a number of bits to take away from that count.

A field that runs past the last bit of the word continues from bit position 0. The part from the start position to the end of the word comes first, and the part taken from the top of the word follows it. Once the field is isolated, the character index moves on by the character count, modulo eight, and the bit offset returns to zero.

An operation is offered with a one-cycle strobe, together with its word, indices and code. The results appear in registers on the next clock edge, and a one-cycle done pulse goes with them. The registers keep their values until the next operation.

Top module: `field_isolator`

## Requirements
- R1: While reset is applied, and in the cycles that follow it, `done` is 0 and `a_out`, `g_out` and `h_out` are all zero.
- R2: `done` is 1 exactly in the cycle that follows a cycle with `op_valid` high, and 0 in every other cycle. Outputs do not change in a cycle that follows one without `op_valid`.
- R3: When the character count `op_code[5:3]` is 0, the operation returns `a_in`, `g_in` and `h_in` unchanged on `a_out`, `g_out` and `h_out`.
- R4: The field length is `op_code[5:3]*6 - op_code[2:0]` bits. The start position is `g_in*6 + h_in`, counted from the most significant bit (vector bit 47 is position 0).
- R5: When start plus length is at most 48, `a_out` holds that field right-justified, with every bit above the field zero.
- R6: When start plus length exceeds 48, the field runs from the start position to position 47 and then continues from position 0. The pieces are joined in that order and the result is right-justified.
- R7: When the length computes as negative (count 1, subtracted bits 7), the length is taken as zero and `a_out` is all zeros.
- R8: For a nonzero count, `g_out` is `(g_in + op_code[5:3]) mod 8` and `h_out` is 0.
- R9: A start position of 48 or more (`g_in` 7 with `h_in` 6 or 7) is reduced modulo 48, so it begins at position 0 or 1.
- R10: Operations offered on consecutive cycles each produce their own result, one cycle after their strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| op_valid | input | 1 | Strobe: an operation is offered this cycle |
| op_code | input | 6 | [5:3] character count, [2:0] bits subtracted from the length |
| a_in | input | 48 | Source word, vector bit 47 is position 0 |
| g_in | input | 3 | Starting character index |
| h_in | input | 3 | Starting bit offset within the character |
| done | output | 1 | One-cycle pulse marking fresh results |
| a_out | output | 48 | Isolated field, right-justified |
| g_out | output | 3 | Updated character index |
| h_out | output | 3 | Updated bit offset |

## Verification
Every result is due exactly one clock edge after its strobe. A strobe driven before edge n has its word, indices and done pulse visible after edge n. The driver applies each operation at a falling edge and pushes the expected word and indices into a queue. The monitor samples at the next falling edge and pops one entry whenever `done` is high, so each comparison falls in the single cycle where that result is valid. A done pulse with an empty queue is counted as a failure, and so are entries still in the queue at the end. Back-to-back strobes check that results keep their order without gaps.

// File: rtl/fld_iso_pkg.sv
package fld_iso_pkg;
  parameter int unsigned WORD_W = 48;
  parameter int unsigned CHAR_W = 6;
  parameter int unsigned IDX_W  = 3;
  localparam int unsigned CODE_W = 2 * IDX_W;
  localparam int unsigned POS_W  = $clog2(WORD_W);
  localparam int unsigned LEN_W  = POS_W + 1;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [LEN_W-1:0]  len_t;
endpackage

// File: rtl/fld_iso_len.sv
module fld_iso_len
  import fld_iso_pkg::*;
#(
  parameter int unsigned CW = CHAR_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic [2*IW-1:0] code,
  output logic [IW-1:0]   chars,
  output logic [LEN_W-1:0] len,
  output logic            active
);
  localparam int unsigned PW = LEN_W + 1;

  logic [PW-1:0] whole_bits;
  logic [PW-1:0] trim_bits;

  always_comb begin
    chars      = code[2*IW-1:IW];
    active     = (chars != '0);
    whole_bits = PW'(chars) * PW'(CW);
    trim_bits  = PW'(code[IW-1:0]);
    // negative length clamps to zero
    if (whole_bits < trim_bits) len = '0;
    else                        len = LEN_W'(whole_bits - trim_bits);
  end
endmodule

// File: rtl/fld_iso_start.sv
module fld_iso_start
  import fld_iso_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned CW = CHAR_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic [IW-1:0]    g_idx,
  input  logic [IW-1:0]    h_idx,
  output logic [POS_W-1:0] start
);
  localparam int unsigned RW = POS_W + 2;

  logic [RW-1:0] raw;

  always_comb begin
    raw = (RW'(g_idx) * RW'(CW)) + RW'(h_idx);
    if (raw >= RW'(W)) start = POS_W'(raw - RW'(W));
    else               start = POS_W'(raw);
  end
endmodule

// File: rtl/fld_iso_rotl.sv
module fld_iso_rotl
  import fld_iso_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [W-1:0]     din,
  input  logic [POS_W-1:0] amt,
  output logic [W-1:0]     dout
);
  logic [W-1:0] stage [POS_W+1];

  assign stage[0] = din;

  for (genvar k = 0; k < POS_W; k++) begin : g_stage
    localparam int unsigned SH = 1 << k;
    assign stage[k+1] = amt[k] ? {stage[k][W-1-SH:0], stage[k][W-1:W-SH]}
                               : stage[k];
  end

  assign dout = stage[POS_W];
endmodule

// File: rtl/field_isolator.sv
module field_isolator
  import fld_iso_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [CODE_W-1:0] op_code,
  input  logic [WORD_W-1:0] a_in,
  input  logic [IDX_W-1:0]  g_in,
  input  logic [IDX_W-1:0]  h_in,
  output logic              done,
  output logic [WORD_W-1:0] a_out,
  output logic [IDX_W-1:0]  g_out,
  output logic [IDX_W-1:0]  h_out
);
  localparam len_t WORD_L = LEN_W'(WORD_W);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  idx_t  chars;
  len_t  len;
  logic  active;
  pos_t  start;
  word_t rot;
  word_t field;
  len_t  rshift;

  fld_iso_len u_len (
    .code   (op_code),
    .chars  (chars),
    .len    (len),
    .active (active)
  );

  fld_iso_start u_start (
    .g_idx (g_in),
    .h_idx (h_in),
    .start (start)
  );

  fld_iso_rotl u_rotl (
    .din  (a_in),
    .amt  (start),
    .dout (rot)
  );

  assign rshift = WORD_L - len;
  assign field  = rot >> rshift;

  // next state
  word_t a_n;
  idx_t  g_n, h_n;
  logic  done_n;

  always_comb begin
    a_n    = a_out;
    g_n    = g_out;
    h_n    = h_out;
    done_n = 1'b0;
    if (op_valid) begin
      done_n = 1'b1;
      if (active) begin
        a_n = field;
        g_n = g_in + chars;
        h_n = '0;
      end else begin
        a_n = a_in;
        g_n = g_in;
        h_n = h_in;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      done  <= 1'b0;
      a_out <= '0;
      g_out <= '0;
      h_out <= '0;
    end else begin
      done <= done_n;
      if (op_valid) begin
        a_out <= a_n;
        g_out <= g_n;
        h_out <= h_n;
      end
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    op_valid |=> done);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !op_valid |=> (!done && $stable(a_out) && $stable(g_out) && $stable(h_out)));

  // R8
  h_clear_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_valid && op_code[CODE_W-1:IDX_W] != '0) |=> (h_out == '0));

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_valid && active) |=> ((a_out >> $past(len)) == '0));

  // R4
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    len <= LEN_W'((1 << IDX_W) - 1) * LEN_W'(CHAR_W));
endmodule

// File: tb/test_field_isolator.sv
module test_field_isolator;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [5:0]  op_code;
  logic [47:0] a_in;
  logic [2:0]  g_in, h_in;
  logic        done;
  logic [47:0] a_out;
  logic [2:0]  g_out, h_out;

  int total = 0;
  int bad   = 0;
  logic [53:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  field_isolator i_field_isolator (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .a_in(a_in), .g_in(g_in), .h_in(h_in),
    .done(done), .a_out(a_out), .g_out(g_out), .h_out(h_out)
  );

  function automatic logic [53:0] model(input logic [5:0] c, input logic [47:0] a,
                                        input logic [2:0] g, input logic [2:0] h);
    int cnt, ln, s, pos;
    logic [47:0] r;
    logic [2:0] gn;
    cnt = int'(c[5:3]);
    if (cnt == 0) return {a, g, h};
    ln = cnt * 6 - int'(c[2:0]);
    if (ln < 0) ln = 0;
    s = (int'(g) * 6 + int'(h)) % 48;
    r = '0;
    for (int i = 0; i < ln; i++) begin
      pos = (s + i) % 48;
      r[ln-1-i] = a[47-pos];
    end
    gn = 3'((int'(g) + cnt) % 8);
    return {r, gn, 3'd0};
  endfunction

  task automatic check(input string tag, input logic [53:0] act, input logic [53:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual a=%h g=%0d h=%0d expected a=%h g=%0d h=%0d",
               tag, act[53:6], act[5:3], act[2:0], exp[53:6], exp[5:3], exp[2:0]);
    end
  endtask

  task automatic issue(input string tag, input logic [5:0] c, input logic [47:0] a,
                       input logic [2:0] g, input logic [2:0] h);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; a_in = a; g_in = g; h_in = h;
    exp_q.push_back(model(c, a, g, h));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_valid = 1'b0;
    end
  endtask

  // monitor: pops an expected entry on each done pulse
  logic mon_en = 1'b0;
  always @(negedge clk) begin
    if (mon_en && done) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R2: actual done=1 expected done=0 (no pending operation)");
      end else begin
        check(tag_q.pop_front(), {a_out, g_out, h_out}, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [47:0] lf;
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; a_in = '0; g_in = '0; h_in = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 during reset", {done, a_out, g_out, h_out}, 55'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {done, a_out, g_out, h_out}, 55'd0);
    mon_en = 1'b1;

    // R4/R5: count 2, minus 1 -> 11 bits from position 8
    issue("R4 R5 plain field", 6'o21, 48'hA5C3_F00F_1234, 3'd1, 3'd2);
    idle(2);
    // R6: wrap, start 39, 18 bits
    issue("R6 wrap field", 6'o30, 48'h8123_4567_89AB, 3'd6, 3'd3);
    idle(2);
    // R3: count zero passes through
    issue("R3 zero count", 6'o07, 48'hDEAD_BEEF_CAFE, 3'd5, 3'd4);
    idle(2);
    // R7: negative length gives zero word
    issue("R7 negative length", 6'o17, 48'hFFFF_FFFF_FFFF, 3'd2, 3'd1);
    idle(2);
    // R9: start 48 -> 0, start 49 -> 1
    issue("R9 start 48", 6'o20, 48'hC000_0000_0001, 3'd7, 3'd6);
    idle(1);
    issue("R9 start 49", 6'o20, 48'hC000_0000_0001, 3'd7, 3'd7);
    idle(2);
    // R8: index wraps modulo 8
    issue("R8 index wrap", 6'o53, 48'h0F0F_0F0F_0F0F, 3'd6, 3'd5);
    idle(2);
    // R5: longest field, 42 bits from position 0
    issue("R5 max length", 6'o70, 48'h9876_5432_10FE, 3'd0, 3'd0);
    idle(2);
    // R6: longest field, wrapping
    issue("R6 max length wrap", 6'o70, 48'h1357_9BDF_0246, 3'd5, 3'd2);
    idle(2);
    // R10: back-to-back stream
    lf = 48'h1F2E_3D4C_5B6A;
    for (int k = 0; k < 40; k++) begin
      lf = {lf[46:0], lf[47] ^ lf[46] ^ lf[20] ^ lf[19]};
      issue("R10 stream", lf[5:0], lf, lf[8:6], lf[11:9]);
      if (k % 7 == 6) idle(1);
    end
    idle(3);
    // R2: outputs held with no strobe
    check("R2 hold after idle", {a_out, g_out, h_out},
          model(lf[5:0], lf, lf[8:6], lf[11:9]));
    total++;
    if (exp_q.size() != 0 || done !== 1'b0) begin
      bad++;
      $display("FAIL R2: actual pending=%0d done=%b expected pending=0 done=0",
               exp_q.size(), done);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule